// File: doc/BRIEF.md
# Multi-Cycle Variable-Length Instruction Processor Core

This block is an unpipelined 32-bit processor core. It works through each instruction in a fixed series of states and uses one external synchronous memory for both instructions and data. Every instruction begins with one word that carries an 8-bit opcode and three 5-bit register indices. Loads, the immediate load, stores and jumps also take a second word from the next address, which holds a full 32-bit address or constant. Two further forms take their memory address from a register instead.

The core holds a 32-entry register file, a program counter, an instruction register and an address register. It does no arithmetic of its own. For the twelve ALU opcodes it presents the opcode and both register operands to an external ALU, takes back the result and writes it to the destination register. The memory takes an address and a read-not-write strobe. When the strobe is high, the addressed word appears on the read-data input one cycle after the address. When the strobe is low, the write data is stored at that clock edge.

Top module: `mcyc_core`

## Requirements
- R1: Reset is synchronous and active high. It clears the program counter and all 32 registers to zero. While reset is held, the core drives address 0 with the strobe high (read). The first fetch after reset is from address 0.
- R2: The first instruction word is split into fields as follows: opcode in bits 31-24, destination index in bits 23-19, operand-1 index in bits 18-14 and operand-2 index in bits 13-9. For opcodes 0x00 to 0x0B, the core drives alu_op with the opcode, alu_a with register operand-1 and alu_b with register operand-2. It writes alu_res to the destination register. The instruction takes 4 cycles.
- R3: The immediate load (0x31) writes its second word into the destination register. It takes 4 cycles.
- R4: The direct load (0x30) reads memory at the address held in its second word and writes that word to the destination register. It takes 6 cycles.
- R5: The direct store (0x20) writes register operand-1 to the address held in its second word. The write happens in the 5th cycle, which is the instruction's last cycle.
- R6: The indirect store (0x22) writes register operand-1 to the address held in the destination register. The write happens in its 3rd and last cycle. The indirect load (0x32) reads from the address held in register operand-1 into the destination register. It takes 4 cycles.
- R7: The jump (0x40) loads the program counter with its second word. The conditional jump (0x41) does the same only when register operand-1 is zero; otherwise execution continues after its second word. Both take 4 cycles.
- R8: Opcode 0x10 and every opcode not listed here change no register and no memory word. They take 2 cycles.
- R9: Each fetched word comes from the address after the previous fetch, unless a jump intervenes. A two-word instruction that does not jump leaves the program counter just past its second word.
- R10: The strobe goes low only in the write cycle of a store, once per executed store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Store data |
| mem_rnw | output | 1 | High: read, low: write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read address |
| alu_op | output | 8 | Opcode passed to the ALU |
| alu_a | output | 32 | First ALU operand |
| alu_b | output | 32 | Second ALU operand |
| alu_res | input | 32 | ALU result, combinational |

## Verification
Every instruction has a fixed cycle count: 2, 3, 4, 5 or 6 cycles, depending on its class. The bench therefore adds up these counts while it assembles the program and works out the exact cycle in which each store must drive the strobe low. Store writes serve as the only window on register contents. A monitor samples the strobe on the falling edge and records the cycle number, address and data of every write. Each record is then compared against the predicted write for that cycle, so a wrong state count, a wrong fetch address or a write that is missing or extra appears as a mismatch. An exhaustive pass over all twelve ALU opcodes with three operand pairs exercises R2.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

    localparam int WORD_W = 32;
    localparam int OPC_W  = 8;
    localparam int RIDX_W = 5;
    localparam int NREG   = 1 << RIDX_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [OPC_W-1:0]  opc_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam opc_t OP_ALU_LAST = 8'h0B;
    localparam opc_t OP_NOP      = 8'h10;
    localparam opc_t OP_STO      = 8'h20;
    localparam opc_t OP_STOR     = 8'h22;
    localparam opc_t OP_LD       = 8'h30;
    localparam opc_t OP_LDI      = 8'h31;
    localparam opc_t OP_LDR      = 8'h32;
    localparam opc_t OP_JMP      = 8'h40;
    localparam opc_t OP_JZ       = 8'h41;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_FETCH2, S_EXEC, S_MEM, S_WB
    } state_t;

    // Upper bits of the first instruction word, most significant first.
    typedef struct packed {
        opc_t  opcode;
        ridx_t dst;
        ridx_t op1;
        ridx_t op2;
    } fields_t;

    function automatic logic is_alu(input opc_t o);
        return o <= OP_ALU_LAST;
    endfunction

    function automatic logic is_two_word(input opc_t o);
        return (o == OP_LD) || (o == OP_LDI) || (o == OP_STO) ||
               (o == OP_JMP) || (o == OP_JZ);
    endfunction

    function automatic logic is_reg_ind(input opc_t o);
        return (o == OP_STOR) || (o == OP_LDR);
    endfunction

endpackage

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
    parameter  int N  = 32,
    parameter  int W  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra_a,
    input  logic [IW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];

    // R3: a write is visible at its index on the following cycle
    assert_rf_write_R3: assert property (@(posedge clk) disable iff (rst)
        we |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
    import mcyc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opc_t   dec_op,
    input  opc_t   ir_op,
    output state_t state
);

    state_t nxt;

    always_comb begin
        nxt = S_FETCH;
        unique case (state)
            S_FETCH:  nxt = S_DECODE;
            S_DECODE: begin
                if (is_two_word(dec_op))     nxt = S_FETCH2;
                else if (is_reg_ind(dec_op)) nxt = S_MEM;
                else if (is_alu(dec_op))     nxt = S_EXEC;
                else                         nxt = S_FETCH;
            end
            S_FETCH2: nxt = S_EXEC;
            S_EXEC: begin
                if (ir_op == OP_LD || ir_op == OP_STO) nxt = S_MEM;
                else if (is_alu(ir_op))                nxt = S_WB;
                else                                   nxt = S_FETCH;
            end
            S_MEM:    nxt = (ir_op == OP_LD || ir_op == OP_LDR) ? S_WB : S_FETCH;
            S_WB:     nxt = S_FETCH;
            default:  nxt = S_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= nxt;
    end

    // R2: every fetch is followed by a decode
    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH) |=> (state == S_DECODE));

endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
    import mcyc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_rnw,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [OPC_W-1:0]  alu_op,
    output logic [WORD_W-1:0] alu_a,
    output logic [WORD_W-1:0] alu_b,
    input  logic [WORD_W-1:0] alu_res
);

    localparam int FW = $bits(fields_t);

    state_t  state;
    fields_t ir_q;
    fields_t rd_f;
    word_t   pc_q, ar_q, res_q;
    word_t   rd_a, rd_b, wb_data;
    ridx_t   ra_a;
    logic    we;
    logic    unused_low;

    assign rd_f       = fields_t'(mem_rdata[WORD_W-1 -: FW]);
    assign unused_low = ^mem_rdata[WORD_W-FW-1:0];

    mcyc_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .dec_op (rd_f.opcode),
        .ir_op  (ir_q.opcode),
        .state  (state)
    );

    // In decode the word is still on the read bus; the indirect store reads
    // its address from the destination index, all else from operand-1.
    always_comb begin
        if (state == S_DECODE)
            ra_a = (rd_f.opcode == OP_STOR) ? rd_f.dst : rd_f.op1;
        else
            ra_a = ir_q.op1;
    end

    always_comb begin
        we      = 1'b0;
        wb_data = res_q;
        if (state == S_EXEC && ir_q.opcode == OP_LDI) begin
            we      = 1'b1;
            wb_data = mem_rdata;
        end else if (state == S_WB) begin
            we      = 1'b1;
            wb_data = is_alu(ir_q.opcode) ? res_q : mem_rdata;
        end
    end

    mcyc_regfile #(.N(NREG), .W(WORD_W)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .we   (we),
        .wa   (ir_q.dst),
        .wd   (wb_data),
        .ra_a (ra_a),
        .ra_b (ir_q.op2),
        .rd_a (rd_a),
        .rd_b (rd_b)
    );

    assign mem_addr  = (state == S_MEM) ? ar_q : pc_q;
    assign mem_rnw   = !(state == S_MEM &&
                         (ir_q.opcode == OP_STO || ir_q.opcode == OP_STOR));
    assign mem_wdata = rd_a;
    assign alu_op    = ir_q.opcode;
    assign alu_a     = rd_a;
    assign alu_b     = rd_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            ar_q  <= '0;
            res_q <= '0;
            ir_q  <= '0;
        end else begin
            unique case (state)
                S_FETCH, S_FETCH2: pc_q <= pc_q + 1'b1;
                S_DECODE: begin
                    ir_q <= rd_f;
                    ar_q <= rd_a;
                end
                S_EXEC: begin
                    ar_q  <= mem_rdata;
                    res_q <= alu_res;
                    if (ir_q.opcode == OP_JMP ||
                        (ir_q.opcode == OP_JZ && rd_a == '0))
                        pc_q <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // R1: reset returns the program counter to zero and the FSM to fetch
    assert_reset_pc_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && state == S_FETCH));

    // R9: each fetch advances the program counter by one
    assert_fetch_advance_R9: assert property (@(posedge clk) disable iff (rst)
        (state == S_FETCH || state == S_FETCH2) |=> (pc_q == $past(pc_q) + 32'd1));

    // R7: a conditional jump on a non-zero register keeps the program counter
    assert_jz_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_EXEC && ir_q.opcode == OP_JZ && rd_a != '0) |=> $stable(pc_q));

    // R5: a memory write is always the last cycle of its instruction
    assert_store_ends_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_rnw |=> (state == S_FETCH));

    // R8: an opcode outside every known class returns to fetch after decode
    assert_noop_short_R8: assert property (@(posedge clk) disable iff (rst)
        (state == S_DECODE && !is_alu(rd_f.opcode) && !is_two_word(rd_f.opcode) &&
         !is_reg_ind(rd_f.opcode)) |=> (state == S_FETCH && $stable(pc_q)));

endmodule

// File: tb/mcyc_core_bench.sv
module mcyc_core_bench;
    import mcyc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, alu_a, alu_b, alu_res;
    logic [7:0]  alu_op;
    logic        mem_rnw;

    always #4 clk = ~clk;

    mcyc_core u_mcyc_core (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rnw(mem_rnw),
        .mem_rdata(mem_rdata),
        .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b), .alu_res(alu_res)
    );

    // bench ALU
    function automatic logic [31:0] alu_f(input logic [7:0] op,
                                          input logic [31:0] a, input logic [31:0] b);
        case (op)
            8'h00, 8'h02: return a + b;
            8'h01, 8'h03: return a - b;
            8'h04: return a * b;
            8'h05: return (b == 0) ? 32'd0 : 32'($signed(a) / $signed(b));
            8'h06: return {31'd0, (a != 0) && (b != 0)};
            8'h07: return a & b;
            8'h08: return {31'd0, (a != 0) || (b != 0)};
            8'h09: return a | b;
            8'h0A: return {31'd0, a == 0};
            8'h0B: return ~a;
            default: return 32'hDEAD_0000;
        endcase
    endfunction

    assign alu_res = alu_f(alu_op, alu_a, alu_b);

    // memory: registered read, write on strobe low
    logic [31:0] mem [1024];
    always @(posedge clk) begin
        if (!mem_rnw) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // program builder and model
    int          wp, t, nexp, halt_at;
    logic [31:0] mdl [32];
    logic [31:0] mm  [1024];
    int          ex_cyc  [64];
    logic [31:0] ex_addr [64];
    logic [31:0] ex_data [64];
    string       ex_tag  [64];

    int          cyc, nlog;
    int          lg_cyc  [64];
    logic [31:0] lg_addr [64];
    logic [31:0] lg_data [64];

    int n_chk, n_bad;
    bit done;

    function automatic logic [31:0] enc(input logic [7:0] op, input int d,
                                        input int a, input int b);
        return {op, 5'(d), 5'(a), 5'(b), 9'd0};
    endfunction

    task automatic put(input logic [31:0] w);
        mem[wp] = w;
        wp++;
    endtask

    task automatic expect_wr(input int c, input logic [31:0] a,
                             input logic [31:0] d, input string tag);
        ex_cyc[nexp] = c; ex_addr[nexp] = a; ex_data[nexp] = d; ex_tag[nexp] = tag;
        nexp++;
        mm[a[9:0]] = d;
    endtask

    task automatic i_ldi(input int d, input logic [31:0] imm);
        put(enc(OP_LDI, d, 0, 0)); put(imm);
        mdl[d] = imm; t += 4;
    endtask

    task automatic i_one(input logic [7:0] op, input int d, input int a, input int b);
        put(enc(op, d, a, b));
        if (op <= OP_ALU_LAST) begin
            mdl[d] = alu_f(op, mdl[a], mdl[b]);
            t += 4;
        end else begin
            t += 2;
        end
    endtask

    task automatic i_sto(input int r, input logic [31:0] a, input bit live, input string tag);
        put(enc(OP_STO, 0, r, 0)); put(a);
        if (live) begin
            expect_wr(t + 4, a, mdl[r], tag);
            t += 5;
        end
    endtask

    task automatic i_stor(input int dr, input int r, input string tag);
        put(enc(OP_STOR, dr, r, 0));
        expect_wr(t + 2, mdl[dr], mdl[r], tag);
        t += 3;
    endtask

    task automatic i_ld(input int d, input logic [31:0] a);
        put(enc(OP_LD, d, 0, 0)); put(a);
        mdl[d] = mm[a[9:0]]; t += 6;
    endtask

    task automatic i_ldr(input int d, input int r);
        put(enc(OP_LDR, d, r, 0));
        mdl[d] = mm[mdl[r][9:0]]; t += 4;
    endtask

    task automatic i_jz_over(input int r, input int sr, input logic [31:0] sa);
        int start;
        bit taken;
        start = wp;
        taken = (mdl[r] == 0);
        put(enc(OP_JZ, 0, r, 0)); put(32'(start + 4));
        t += 4;
        i_sto(sr, sa, !taken, "R7");
    endtask

    task automatic i_jmp_over(input int sr, input logic [31:0] sa);
        int start;
        start = wp;
        put(enc(OP_JMP, 0, 0, 0)); put(32'(start + 4));
        t += 4;
        i_sto(sr, sa, 1'b0, "R7");
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_rnw) begin
                if (nlog < 64) begin
                    lg_cyc[nlog]  = cyc;
                    lg_addr[nlog] = mem_addr;
                    lg_data[nlog] = mem_wdata;
                end
                nlog++;
            end
            cyc++;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, t);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] opa [3];
        logic [31:0] opb [3];
        opa[0] = 32'd5;          opb[0] = 32'd3;
        opa[1] = 32'd0;          opb[1] = 32'd7;
        opa[2] = 32'hFFFF_FFF0;  opb[2] = 32'h0000_0010;
        for (int i = 0; i < 1024; i++) begin mem[i] = '0; mm[i] = '0; end
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        wp = 0; t = 0; nexp = 0; cyc = 0; nlog = 0; n_chk = 0; n_bad = 0; done = 0;
        mem[800] = 32'hA5A5_0001; mm[800] = 32'hA5A5_0001;
        mem[810] = 32'hBEEF_0002; mm[810] = 32'hBEEF_0002;

        // R1: register never written reads back zero
        i_sto(7, 32'd900, 1'b1, "R1");
        // R2: every ALU opcode over three operand pairs
        for (int k = 0; k < 3; k++) begin
            i_ldi(10 + k, opa[k]);
            i_ldi(20 + k, opb[k]);
            for (int op = 0; op < 12; op++) begin
                i_one(8'(op), 1 + op, 10 + k, 20 + k);
                i_sto(1 + op, 32'(910 + op), 1'b1, "R2");
            end
        end
        // R3, R5
        i_ldi(4, 32'h1234_5678);
        i_sto(4, 32'd930, 1'b1, "R3");
        // R8: no-op and unknown opcodes leave r4 alone
        i_one(8'h0C, 4, 10, 20);
        i_one(OP_NOP, 4, 10, 20);
        i_one(8'h77, 4, 10, 20);
        i_one(8'hFF, 4, 11, 21);
        i_sto(4, 32'd931, 1'b1, "R8");
        // R4
        i_ld(5, 32'd800);
        i_sto(5, 32'd932, 1'b1, "R4");
        // R6
        i_ldi(6, 32'd810);
        i_ldr(8, 6);
        i_sto(8, 32'd933, 1'b1, "R6");
        i_ldi(9, 32'd940);
        i_stor(9, 4, "R6");
        i_ld(30, 32'd940);
        i_sto(30, 32'd934, 1'b1, "R5");
        // R7: jump skips, zero-test taken skips, non-zero falls through
        i_jmp_over(4, 32'd950);
        i_jz_over(0, 4, 32'd951);
        i_jz_over(4, 5, 32'd952);
        halt_at = wp;
        put(enc(OP_JMP, 0, 0, 0)); put(32'(halt_at));

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mem_addr == 0 && mem_rnw, "R1", "reset bus", {mem_addr[30:0], mem_rnw}, 32'd1);
        @(posedge clk);
        rst <= 1'b0;

        wait (cyc >= t + 40);
        @(negedge clk);
        check(mem_addr >= 32'(halt_at) && mem_addr <= 32'(halt_at + 2), "R9",
              "halt loop address", mem_addr, 32'(halt_at));

        for (int i = 0; i < nexp; i++) begin
            if (i < nlog && i < 64)
                check(lg_cyc[i] == ex_cyc[i] && lg_addr[i] == ex_addr[i] &&
                      lg_data[i] == ex_data[i], ex_tag[i],
                      $sformatf("write %0d cyc %0d/%0d addr", i, lg_cyc[i], ex_cyc[i]),
                      lg_data[i] ^ lg_addr[i], ex_data[i] ^ ex_addr[i]);
            else
                check(1'b0, ex_tag[i], "missing write", 32'(nlog), 32'(nexp));
        end
        check(nlog == nexp, "R10", "write count", 32'(nlog), 32'(nexp));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule